// File: doc/BRIEF.md
# Heartbeat Watchdog with Edge Clearing

This block watches a heartbeat line that a processor toggles while its software runs correctly. A timer counts clock cycles since the heartbeat last changed level. Either a rising or a falling change restarts the timer. If the line stays at one level until the count reaches a parameterised limit, the active-low output `wdo_n` goes low. It stays low until a new heartbeat change clears the timer.

The heartbeat arrives as a data bit plus a flag that says whether the line is actually driven. An undriven line, such as a floating or three-stated one, turns the watchdog off. Two status inputs come from the chip's reset generator. `sys_rst` clears the timer for as long as it is high. `supply_low` pulls the output low at once and lets it go as soon as the supply recovers.

Top module: `hb_watchdog`

## Requirements
- R1: After `rst_n` is released with all inputs low, `wdo_n` is high.
- R2: A change of `hb_data` sampled at rising edge k clears the timer at edge k+2, after two synchroniser stages and the edge detector. If `hb_data` then keeps its level, `wdo_n` goes low right after edge k+2+TIMEOUT_CYC and not earlier.
- R3: A low-to-high change and a high-to-low change of `hb_data` both clear the timer. A heartbeat that changes level at intervals shorter than the timeout keeps `wdo_n` high.
- R4: While `sys_rst` is high at a rising edge, the timer is cleared at that edge, and `wdo_n` is high after it unless `supply_low` is high.
- R5: When `hb_driven` is low, two edges later (after synchronisation) the watchdog is disabled. `wdo_n` is then high unless `supply_low` is high, and the timer is held at zero. When `hb_driven` returns, a full timeout must pass from zero before `wdo_n` falls.
- R6: Once `wdo_n` has fallen on a timeout, it stays low for any number of cycles until a heartbeat change, `sys_rst` or disabling clears the timer. The timer saturates and does not wrap.
- R7: `supply_low` high drives `wdo_n` low in the same cycle, without any clock edge. When `supply_low` falls, `wdo_n` shows the timer state again in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| sys_rst | input | 1 | System reset active (high), clears the timer |
| supply_low | input | 1 | Supply below threshold (high), forces the output low |
| hb_data | input | 1 | Heartbeat level from the processor |
| hb_driven | input | 1 | High when the heartbeat line is actively driven |
| wdo_n | output | 1 | Active-low watchdog output |

## Verification
The assertions assume that `hb_data` and `hb_driven` can change at any cycle, because they pass through a synchroniser. They also assume that `sys_rst` and `supply_low` are synchronous to `clk`, so that they can be related to the timer one edge later. The bench drives every input only on the falling clock edge. It applies random heartbeat intervals from a fixed seed, both shorter and longer than the timeout, and random short bursts of the status inputs. It also runs directed cases for each requirement: exact timeout, saturation, and return from the undriven state.

// File: rtl/wd_pkg.sv
package wd_pkg;

  // counter width able to hold the value lim
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // next count with saturation at lim
  function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/hb_edge.sv
module hb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic toggled
);

  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= level;
  end

  assign toggled = level ^ last_q;

endmodule

// File: rtl/wd_timer.sv
module wd_timer
  import wd_pkg::*;
#(
  parameter int unsigned LIMIT = 64,
  parameter int unsigned CW    = cnt_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [CW-1:0] count,
  output logic          expired
);

  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (clear) count_q <= '0;
    else            count_q <= CW'(sat_inc(int'(count_q), LIMIT));
  end

  assign count   = count_q;
  assign expired = (count_q == LIM);

endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog
  import wd_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic supply_low,
  input  logic hb_data,
  input  logic hb_driven,
  output logic wdo_n
);

  localparam int unsigned CW = cnt_width(TIMEOUT_CYC);

  logic [1:0]    hb_raw;
  logic [1:0]    hb_sync;
  logic          hb_level;
  logic          hb_on;
  logic          hb_edge_seen;
  logic          tmr_clear;
  logic [CW-1:0] tmr_count;
  logic          tmr_expired;
  logic          wd_fault;

  assign hb_raw = {hb_driven, hb_data};

  hb_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (hb_raw),
    .sync_out (hb_sync)
  );

  assign hb_level = hb_sync[0];
  assign hb_on    = hb_sync[1];

  hb_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (hb_level),
    .toggled (hb_edge_seen)
  );

  assign tmr_clear = hb_edge_seen | sys_rst | ~hb_on;

  wd_timer #(.LIMIT(TIMEOUT_CYC), .CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .count   (tmr_count),
    .expired (tmr_expired)
  );

  assign wd_fault = hb_on & tmr_expired;
  assign wdo_n    = ~(supply_low | wd_fault);

endmodule

// File: rtl/hb_watchdog_chk.sv
module hb_watchdog_chk #(
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned CW          = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sys_rst,
  input logic          supply_low,
  input logic          wdo_n,
  input logic          hb_on,
  input logic          hb_edge_seen,
  input logic          tmr_clear,
  input logic [CW-1:0] tmr_count
);

  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC);

  // R7
  supply_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> !wdo_n);

  // R2
  edge_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_edge_seen |=> (tmr_count == '0));

  // R4
  sysrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (tmr_count == '0) && (wdo_n || supply_low));

  // R5
  disabled_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_on |-> (wdo_n || supply_low));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_count <= LIM);

  // R6
  stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n && !supply_low && !tmr_clear) |=> (tmr_count == LIM));

  // R2
  low_means_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n && !supply_low) |-> (tmr_count == LIM) && hb_on);

endmodule

bind hb_watchdog hb_watchdog_chk #(.TIMEOUT_CYC(TIMEOUT_CYC), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sys_rst      (sys_rst),
  .supply_low   (supply_low),
  .wdo_n        (wdo_n),
  .hb_on        (hb_on),
  .hb_edge_seen (hb_edge_seen),
  .tmr_clear    (tmr_clear),
  .tmr_count    (tmr_count)
);

// File: tb/tb_hb_watchdog.sv
`timescale 1ns/1ps
module tb_hb_watchdog;

  localparam int unsigned T = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst = 1'b0;
  logic supply_low = 1'b0;
  logic hb_data = 1'b0;
  logic hb_driven = 1'b0;
  logic wdo_n;

  int unsigned errors = 0;
  int unsigned checks = 0;
  string       tag = "R1";
  bit          done = 1'b0;

  always #2 clk = ~clk;

  hb_watchdog #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .supply_low(supply_low),
    .hb_data(hb_data), .hb_driven(hb_driven), .wdo_n(wdo_n)
  );

  // reference: input seen two edges late, then "quiet age" since last change
  logic        r_d1, r_d2, r_d3, r_v1, r_v2;
  int unsigned quiet;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_d1 <= 0; r_d2 <= 0; r_d3 <= 0; r_v1 <= 0; r_v2 <= 0; quiet <= 0;
    end else begin
      r_d1 <= hb_data;  r_d2 <= r_d1;  r_d3 <= r_d2;
      r_v1 <= hb_driven; r_v2 <= r_v1;
      if (sys_rst || !r_v2 || (r_d2 != r_d3)) quiet <= 0;
      else if (quiet < T) quiet <= quiet + 1;
    end
  end

  function automatic bit want_out(input bit sl, input bit on, input int unsigned age);
    if (sl) return 1'b0;
    if (on && age >= T) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_now();
    bit e;
    e = want_out(supply_low, r_v2, quiet);
    checks++;
    if (wdo_n !== e) begin
      errors++;
      $display("FAIL %s: wdo_n=%0b expected %0b (t=%0t)", tag, wdo_n, e, $time);
    end
  endtask

  // one cycle: check at the falling edge, then apply new inputs
  task automatic step(input bit d, input bit v, input bit sr, input bit sl);
    @(negedge clk);
    check_now();
    hb_data = d; hb_driven = v; sys_rst = sr; supply_low = sl;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) step(hb_data, hb_driven, sys_rst, supply_low);
  endtask

  task automatic expect_level(input bit e, input string what);
    @(negedge clk);
    checks++;
    if (wdo_n !== e) begin
      errors++;
      $display("FAIL %s (%s): wdo_n=%0b expected %0b", tag, what, wdo_n, e);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    tag = "R1";
    expect_level(1'b1, "after reset");

    // R2: exact timeout after a rising change
    tag = "R2";
    step(1, 1, 0, 0);
    hold(T + 1);
    expect_level(1'b1, "one cycle before timeout");
    expect_level(1'b0, "at timeout");

    // R6: stays low, saturates
    tag = "R6";
    hold(3 * T);
    expect_level(1'b0, "long hold");

    // R3: falling change clears, then rising change clears
    tag = "R3";
    step(0, 1, 0, 0);
    hold(T / 2);
    step(1, 1, 0, 0);
    hold(T / 2);
    step(0, 1, 0, 0);
    hold(T - 2);
    expect_level(1'b1, "fast heartbeat");

    // R4: system reset clears the timer
    tag = "R4";
    hold(T + 4);
    expect_level(1'b0, "timed out before sys_rst");
    step(0, 1, 1, 0);
    step(0, 1, 0, 0);
    hold(3);
    expect_level(1'b1, "after sys_rst");

    // R5: undriven disables; restart from zero
    tag = "R5";
    hold(T + 4);
    step(0, 0, 0, 0);
    hold(T * 2);
    expect_level(1'b1, "undriven");
    step(0, 1, 0, 0);
    hold(T);
    expect_level(1'b1, "restarted");
    hold(4);

    // R7: supply low forces low, immediate release
    tag = "R7";
    step(1, 1, 0, 1);
    hold(5);
    step(1, 1, 0, 0);
    hold(3);
    expect_level(1'b1, "after supply recovers");

    // random mix
    tag = "R2";
    for (int k = 0; k < 300; k++) begin
      int unsigned gap;
      bit v, sr, sl;
      gap = $urandom_range(2 * T + 6, 1);
      v   = ($urandom_range(9, 0) != 0);
      sr  = ($urandom_range(19, 0) == 0);
      sl  = ($urandom_range(14, 0) == 0);
      step(~hb_data, v, sr, sl);
      step(hb_data, v, 0, sl);
      step(hb_data, v, 0, 0);
      hold(gap);
    end
    hold(4);
    done = 1'b1;
  end

  initial begin
    int unsigned n;
    n = 0;
    while (!done && n < 150000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: bench hung, done=0 expected 1");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule